// File: doc/BRIEF.md
# Memory Parity Error Status Capture

This block keeps the error status for a parity-protected local memory. It owns two control bits: one enables parity checking and one forces bad parity onto memory writes. It also holds sticky flags for parity errors seen on CPU reads of local memory, on CPU reads made through the address map, and on reads made by external DMA masters. The parity checker reports each error as a single-cycle pulse together with the full local address.

For the first CPU error, and separately for the first DMA error, the block stores the address of the failing page. A later error does not replace a stored page. A CPU error that arrives while a CPU flag is already set raises a lost-error flag instead. Software reads and writes the status word and reads the two page registers through a small register port with combinational read data. Error flags are cleared by writing a one to them. A CPU error also gives a one-cycle trap pulse. DMA errors never give a trap pulse.

Top module: `perr_status_unit`

## Requirements
- R1: After asynchronous reset, all state reads as zero and `force_bad_par` and `cpu_trap` are low. A cycle with `pwr_good` low, or with `bus_init_wr` high, clears all state at the next clock edge. This clear takes priority over events and register writes in the same cycle.
- R2: While the parity-enable bit (status bit 0) is clear, error pulses on `cpu_loc_err`, `cpu_map_err` and `dma_err` change no flag, no page register and no trap.
- R3: A status write (`reg_wr` high, `reg_sel`=0) loads bit 0 (parity enable) and bit 1 (wrong parity) from `reg_wdata`. A one written to bit 2 (DMA error), bit 3 (CPU mapped error), bit 4 (CPU local error) or bit 5 (lost error) clears that flag. A zero written to any of these four bits leaves it unchanged.
- R4: An enabled CPU error pulse raises `cpu_trap` for exactly the following cycle. An enabled DMA error pulse sets status bit 2 and leaves `cpu_trap` low.
- R5: Status bit 5 (lost error) sets on an enabled CPU error pulse when bit 3 or bit 4 is already set.
- R6: When an enabled CPU error sets a CPU flag while neither CPU flag is set, address bits 23:9 of `cpu_err_addr` are loaded into CPU page register bits 14:0. Bits 31:15 of that register read as zero.
- R7: While its flag or flags stay set, a page register holds its value against further error pulses.
- R8: The DMA page register loads `dma_err_addr` bits 23:9 into bits 14:0 when an enabled DMA error finds status bit 2 clear. It then holds until bit 2 is cleared. Bits 31:15 read as zero.
- R9: `force_bad_par` equals status bit 1 at all times.
- R10: If an enabled error pulse and a one-to-clear write to the same flag occur in the same cycle, the flag ends up set.
- R11: Status bits 31:6 always read as zero.
- R12: `reg_sel` selects the read data: 0 is status, 1 is the CPU page register, 2 is the DMA page register, and 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | DC power good; low clears all state |
| bus_init_wr | input | 1 | Write strobe to the bus-initialize register; clears all state |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| cpu_loc_err | input | 1 | Parity error pulse, CPU read of local memory |
| cpu_map_err | input | 1 | Parity error pulse, CPU read through the address map |
| cpu_err_addr | input | 24 | Local address of the CPU error |
| dma_err | input | 1 | Parity error pulse, DMA read of local memory |
| dma_err_addr | input | 24 | Local address of the DMA error |
| force_bad_par | output | 1 | Tells the write path to store inverted parity |
| cpu_trap | output | 1 | One-cycle pulse after an accepted CPU error |

## Verification
The hardest states to reach from the ports need a CPU error flag to be set first. These are a second error that must set lost-error while the stored page stays unchanged, and an error that lands in the same cycle as a one-to-clear write. Directed sequences first enable checking and plant a first error. They then apply a second error, an error together with a clear, and clears caused by a power-good drop and by a bus-initialize write. A long run of seeded random cycles follows. It uses frequent error pulses, occasional status writes and rare global clears, so the flags keep building up and draining while a bench model tracks every register.

// File: rtl/perr_pkg.sv
package perr_pkg;

    // status word bit positions (software-visible layout)
    localparam int ST_PEN  = 0;
    localparam int ST_WPAR = 1;
    localparam int ST_DMA  = 2;
    localparam int ST_CMAP = 3;
    localparam int ST_CLOC = 4;
    localparam int ST_LOST = 5;
    localparam int ST_USED = 6;

    // register select codes
    localparam logic [1:0] SEL_STATUS = 2'd0;
    localparam logic [1:0] SEL_CPAGE  = 2'd1;
    localparam logic [1:0] SEL_DPAGE  = 2'd2;

    typedef struct packed {
        logic par_en;
        logic wrong_par;
        logic dma_err;
        logic cpu_map;
        logic cpu_loc;
        logic lost;
        logic trap;
    } perr_flags_t;

endpackage

// File: rtl/perr_flag_unit.sv
module perr_flag_unit
    import perr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_clr_i,
    input  logic              st_wr_i,
    input  logic [DATA_W-1:0] st_wdata_i,
    input  logic              cpu_loc_ev_i,
    input  logic              cpu_map_ev_i,
    input  logic              dma_ev_i,
    output perr_flags_t       flags_o,
    output logic              cpu_cap_o,
    output logic              dma_cap_o
);

    perr_flags_t flags_d, flags_q;

    logic en;
    logic loc_acc, map_acc, dma_acc, cpu_acc;
    logic cpu_held;
    logic clr_dma, clr_map, clr_loc, clr_lost;
    logic unused_wbits;

    assign unused_wbits = ^st_wdata_i[DATA_W-1:ST_USED];

    always_comb begin
        en       = flags_q.par_en;
        loc_acc  = en & cpu_loc_ev_i;
        map_acc  = en & cpu_map_ev_i;
        dma_acc  = en & dma_ev_i;
        cpu_acc  = loc_acc | map_acc;
        cpu_held = flags_q.cpu_loc | flags_q.cpu_map;

        clr_dma  = st_wr_i & st_wdata_i[ST_DMA];
        clr_map  = st_wr_i & st_wdata_i[ST_CMAP];
        clr_loc  = st_wr_i & st_wdata_i[ST_CLOC];
        clr_lost = st_wr_i & st_wdata_i[ST_LOST];

        flags_d = flags_q;

        // control bits follow the status write
        if (st_wr_i) begin
            flags_d.par_en    = st_wdata_i[ST_PEN];
            flags_d.wrong_par = st_wdata_i[ST_WPAR];
        end

        // sticky flags: clear by one, set wins over clear
        flags_d.dma_err = (flags_q.dma_err & ~clr_dma)  | dma_acc;
        flags_d.cpu_map = (flags_q.cpu_map & ~clr_map)  | map_acc;
        flags_d.cpu_loc = (flags_q.cpu_loc & ~clr_loc)  | loc_acc;
        flags_d.lost    = (flags_q.lost    & ~clr_lost) | (cpu_acc & cpu_held);
        flags_d.trap    = cpu_acc;

        cpu_cap_o = cpu_acc & ~cpu_held;
        dma_cap_o = dma_acc & ~flags_q.dma_err;

        if (sync_clr_i) begin
            flags_d   = '0;
            cpu_cap_o = 1'b0;
            dma_cap_o = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign flags_o = flags_q;

    // R2
    no_set_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flags_q.cpu_loc) || $rose(flags_q.cpu_map) || $rose(flags_q.dma_err))
            |-> $past(flags_q.par_en));

    // R5
    lost_needs_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q.lost) |-> $past(flags_q.cpu_loc || flags_q.cpu_map));

    // R10
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_clr_i && en && cpu_loc_ev_i) |=> flags_q.cpu_loc);

    // R1
    global_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_clr_i |=> (flags_q == '0));

endmodule

// File: rtl/perr_addr_hold.sv
module perr_addr_hold #(
    parameter int ADDR_W   = 24,
    parameter int PAGE_LSB = 9,
    localparam int CAP_W   = ADDR_W - PAGE_LSB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_clr_i,
    input  logic             cap_i,
    input  logic             held_i,
    input  logic [CAP_W-1:0] page_i,
    output logic [CAP_W-1:0] page_o
);

    logic [CAP_W-1:0] page_d, page_q;

    always_comb begin
        page_d = page_q;
        if (cap_i) begin
            page_d = page_i;
        end
        if (sync_clr_i) begin
            page_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
        end else begin
            page_q <= page_d;
        end
    end

    assign page_o = page_q;

    // R7
    page_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held_i && $past(held_i)) |-> $stable(page_q));

    // R6
    capture_only_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_i |-> !held_i);

endmodule

// File: rtl/perr_status_unit.sv
module perr_status_unit
    import perr_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 24,
    parameter int PAGE_LSB = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic              bus_init_wr,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              cpu_loc_err,
    input  logic              cpu_map_err,
    input  logic [ADDR_W-1:0] cpu_err_addr,
    input  logic              dma_err,
    input  logic [ADDR_W-1:0] dma_err_addr,
    output logic              force_bad_par,
    output logic              cpu_trap
);

    localparam int CAP_W  = ADDR_W - PAGE_LSB;
    localparam int N_PATH = 2;

    logic        sync_clr;
    logic        st_wr;
    perr_flags_t flags;
    logic        cpu_cap, dma_cap;

    logic [N_PATH-1:0]            cap_v;
    logic [N_PATH-1:0]            held_v;
    logic [N_PATH-1:0][CAP_W-1:0] page_in_v;
    logic [N_PATH-1:0][CAP_W-1:0] page_out_v;
    logic                         unused_low;

    assign sync_clr   = ~pwr_good | bus_init_wr;
    assign st_wr      = reg_wr & (reg_sel == SEL_STATUS);
    assign unused_low = ^{cpu_err_addr[PAGE_LSB-1:0], dma_err_addr[PAGE_LSB-1:0]};

    perr_flag_unit #(.DATA_W(DATA_W)) u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_clr_i   (sync_clr),
        .st_wr_i      (st_wr),
        .st_wdata_i   (reg_wdata),
        .cpu_loc_ev_i (cpu_loc_err),
        .cpu_map_ev_i (cpu_map_err),
        .dma_ev_i     (dma_err),
        .flags_o      (flags),
        .cpu_cap_o    (cpu_cap),
        .dma_cap_o    (dma_cap)
    );

    // path 0 = CPU, path 1 = DMA
    assign cap_v[0]     = cpu_cap;
    assign cap_v[1]     = dma_cap;
    assign held_v[0]    = flags.cpu_loc | flags.cpu_map;
    assign held_v[1]    = flags.dma_err;
    assign page_in_v[0] = cpu_err_addr[ADDR_W-1:PAGE_LSB];
    assign page_in_v[1] = dma_err_addr[ADDR_W-1:PAGE_LSB];

    for (genvar g = 0; g < N_PATH; g++) begin : g_path
        perr_addr_hold #(.ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB)) u_hold (
            .clk        (clk),
            .rst_n      (rst_n),
            .sync_clr_i (sync_clr),
            .cap_i      (cap_v[g]),
            .held_i     (held_v[g]),
            .page_i     (page_in_v[g]),
            .page_o     (page_out_v[g])
        );
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel)
            SEL_STATUS: begin
                reg_rdata[ST_PEN]  = flags.par_en;
                reg_rdata[ST_WPAR] = flags.wrong_par;
                reg_rdata[ST_DMA]  = flags.dma_err;
                reg_rdata[ST_CMAP] = flags.cpu_map;
                reg_rdata[ST_CLOC] = flags.cpu_loc;
                reg_rdata[ST_LOST] = flags.lost;
            end
            SEL_CPAGE: reg_rdata[CAP_W-1:0] = page_out_v[0];
            SEL_DPAGE: reg_rdata[CAP_W-1:0] = page_out_v[1];
            default:   reg_rdata = '0;
        endcase
    end

    assign force_bad_par = flags.wrong_par;
    assign cpu_trap      = flags.trap;

    // R4
    trap_from_cpu_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_trap |-> $past(cpu_loc_err || cpu_map_err));

    // R6
    page_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel != SEL_STATUS) |-> (reg_rdata[DATA_W-1:CAP_W] == '0));

    // R11
    status_unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == SEL_STATUS) |-> (reg_rdata[DATA_W-1:ST_USED] == '0));

endmodule

// File: tb/perr_status_unit_bench.sv
module perr_status_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_good = 1'b1;
    logic        bus_init_wr = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cpu_loc_err = 1'b0;
    logic        cpu_map_err = 1'b0;
    logic [23:0] cpu_err_addr = '0;
    logic        dma_err = 1'b0;
    logic [23:0] dma_err_addr = '0;
    logic        force_bad_par;
    logic        cpu_trap;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state
    bit        m_en, m_wp, m_dma, m_map, m_loc, m_lost, m_trap;
    bit [14:0] m_cpage, m_dpage;

    always #2 clk = ~clk;

    perr_status_unit u_perr_status_unit (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .bus_init_wr(bus_init_wr),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cpu_loc_err(cpu_loc_err), .cpu_map_err(cpu_map_err), .cpu_err_addr(cpu_err_addr),
        .dma_err(dma_err), .dma_err_addr(dma_err_addr),
        .force_bad_par(force_bad_par), .cpu_trap(cpu_trap)
    );

    function automatic bit [31:0] exp_read(input bit [1:0] sel);
        case (sel)
            2'd0:    return {26'd0, m_lost, m_loc, m_map, m_dma, m_wp, m_en};
            2'd1:    return {17'd0, m_cpage};
            2'd2:    return {17'd0, m_dpage};
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_clear();
        m_en = 0; m_wp = 0; m_dma = 0; m_map = 0; m_loc = 0; m_lost = 0; m_trap = 0;
        m_cpage = '0; m_dpage = '0;
    endtask

    // next state from the current inputs, applied at the coming edge
    task automatic model_step();
        bit wr0, lacc, macc, dacc, cacc, held;
        if (!pwr_good || bus_init_wr) begin
            model_clear();
            return;
        end
        wr0  = reg_wr && (reg_sel == 2'd0);
        lacc = m_en && cpu_loc_err;
        macc = m_en && cpu_map_err;
        dacc = m_en && dma_err;
        cacc = lacc || macc;
        held = m_loc || m_map;
        if (cacc && !held) m_cpage = cpu_err_addr[23:9];
        if (dacc && !m_dma) m_dpage = dma_err_addr[23:9];
        m_lost = (m_lost && !(wr0 && reg_wdata[5])) || (cacc && held);
        m_loc  = (m_loc && !(wr0 && reg_wdata[4])) || lacc;
        m_map  = (m_map && !(wr0 && reg_wdata[3])) || macc;
        m_dma  = (m_dma && !(wr0 && reg_wdata[2])) || dacc;
        m_trap = cacc;
        if (wr0) begin
            m_en = reg_wdata[0];
            m_wp = reg_wdata[1];
        end
    endtask

    task automatic check(input string tag, input bit [31:0] act, input bit [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        bus_init_wr = 0; reg_wr = 0; reg_wdata = '0; pwr_good = 1;
        cpu_loc_err = 0; cpu_map_err = 0; dma_err = 0;
    endtask

    // one clock: model update, edge, then sample 1 ns later
    task automatic tick();
        model_step();
        @(posedge clk);
        #1;
    endtask

    task automatic read_check(input string tag, input bit [1:0] sel);
        reg_sel = sel;
        #0.5;
        check(tag, reg_rdata, exp_read(sel));
    endtask

    task automatic wr_status(input bit [31:0] d);
        idle_inputs(); reg_wr = 1; reg_sel = 2'd0; reg_wdata = d;
        tick();
        idle_inputs();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit [1:0] sel;
        model_clear();
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        for (int s = 0; s < 4; s++) read_check("R1 reset", 2'(s));
        check("R1 reset force_bad_par", {31'd0, force_bad_par}, 32'd0);
        check("R1 reset cpu_trap", {31'd0, cpu_trap}, 32'd0);
        rst_n = 1;
        @(posedge clk); #1;

        // R2 disabled: events ignored
        idle_inputs(); cpu_loc_err = 1; cpu_map_err = 1; dma_err = 1;
        cpu_err_addr = 24'hABCDEF; dma_err_addr = 24'h123456;
        tick(); idle_inputs();
        check("R2 no trap", {31'd0, cpu_trap}, 32'd0);
        read_check("R2 status", 2'd0);
        read_check("R2 cpu page", 2'd1);
        read_check("R2 dma page", 2'd2);

        // enable, wrong parity on
        wr_status(32'h3);
        check("R9 force_bad_par on", {31'd0, force_bad_par}, 32'd1);
        read_check("R3 control bits", 2'd0);

        // first CPU error -> capture, trap
        idle_inputs(); cpu_loc_err = 1; cpu_err_addr = 24'hFFFFFF;
        tick(); idle_inputs();
        check("R4 cpu trap", {31'd0, cpu_trap}, 32'd1);
        read_check("R6 cpu page capture", 2'd1);
        cpu_err_addr = 24'h000200;
        tick();
        check("R4 trap one cycle", {31'd0, cpu_trap}, 32'd0);

        // second error -> lost, page holds
        idle_inputs(); cpu_map_err = 1; cpu_err_addr = 24'h5A5A00;
        tick(); idle_inputs();
        read_check("R5 lost set", 2'd0);
        read_check("R7 cpu page held", 2'd1);

        // DMA error -> flag, no trap, then second DMA holds
        idle_inputs(); dma_err = 1; dma_err_addr = 24'h80FE00;
        tick(); idle_inputs();
        check("R4 dma no trap", {31'd0, cpu_trap}, 32'd0);
        read_check("R8 dma page", 2'd2);
        dma_err = 1; dma_err_addr = 24'h7F0000;
        tick(); idle_inputs();
        read_check("R8 dma page held", 2'd2);

        // write zeros to flags: no effect
        wr_status(32'h3);
        read_check("R3 zero write", 2'd0);

        // same-cycle clear and set
        idle_inputs(); reg_wr = 1; reg_sel = 2'd0; reg_wdata = 32'h3F;
        cpu_loc_err = 1; dma_err = 1; cpu_err_addr = 24'h111111;
        tick(); idle_inputs();
        read_check("R10 set wins", 2'd0);
        read_check("R11 unused", 2'd0);
        read_check("R12 sel3", 2'd3);

        // clear all flags then DMA re-capture
        wr_status(32'h3D);
        read_check("R3 w1c", 2'd0);

        // power-good drop
        idle_inputs(); pwr_good = 0; cpu_loc_err = 1;
        tick(); idle_inputs();
        read_check("R1 pwr drop", 2'd0);
        read_check("R1 pwr drop page", 2'd1);
        check("R9 force_bad_par off", {31'd0, force_bad_par}, 32'd0);

        // bus init
        wr_status(32'h1);
        idle_inputs(); dma_err = 1; dma_err_addr = 24'hFFFFFF;
        tick(); idle_inputs();
        bus_init_wr = 1; reg_wr = 1; reg_wdata = 32'h3;
        tick(); idle_inputs();
        read_check("R1 bus init", 2'd0);
        read_check("R1 bus init page", 2'd2);

        // random phase
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < 4000; i++) begin
            idle_inputs();
            sel = 2'($urandom_range(0, 3));
            reg_sel = sel;
            reg_wr = ($urandom_range(0, 7) == 0);
            reg_wdata = $urandom;
            if ($urandom_range(0, 3) != 0) reg_wdata[0] = 1'b1;
            cpu_loc_err = ($urandom_range(0, 4) == 0);
            cpu_map_err = ($urandom_range(0, 5) == 0);
            dma_err = ($urandom_range(0, 4) == 0);
            cpu_err_addr = 24'($urandom);
            dma_err_addr = 24'($urandom);
            bus_init_wr = ($urandom_range(0, 199) == 0);
            pwr_good = ($urandom_range(0, 199) != 0);
            tick();
            idle_inputs();
            reg_sel = sel;
            #0.5;
            case (sel)
                2'd0: check("R3 random status", reg_rdata, exp_read(sel));
                2'd1: check("R6 random cpu page", reg_rdata, exp_read(sel));
                2'd2: check("R8 random dma page", reg_rdata, exp_read(sel));
                default: check("R12 random sel3", reg_rdata, exp_read(sel));
            endcase
            check("R9 random force_bad_par", {31'd0, force_bad_par}, {31'd0, m_wp});
            check("R4 random trap", {31'd0, cpu_trap}, {31'd0, m_trap});
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule